// File: doc/BRIEF.md
# Dual-Rail Pipeline Stage Controller with Sleep Control

This block supervises one stage of a self-timed, dual-rail pipeline whose combinational logic can be powered down. It watches the dual-rail outputs of the stage's logic and the request arriving from the stage downstream. From these it decides when the upstream stage is asked for a new DATA wavefront and when it is asked for a NULL wavefront. It also drives a sleep line that forces the stage's logic back to NULL while the stage has nothing to do.

Every dual-rail pair is classified on its own. The per-pair results are reduced into three registered flags: complete DATA, complete NULL and illegal code. A small handshake machine acts on those flags and on a registered copy of the downstream request. Its outputs are therefore decoded from state alone, and they move only after the completion flags have moved. DATA and NULL wavefronts alternate: the stage sleeps after handing a DATA set downstream, and wakes only once its outputs read NULL and the next stage asks for DATA again.

Top module: `mtncl_stage_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its idle state: `stage_sleep`=1, `prev_req_data`=0, `data_done`=0, `null_done`=0, `illegal_err`=0.
- R2: `null_done` is 1 in the cycle after an edge at which every pair of `stage_rails` is 00, and 0 otherwise.
- R3: Pair i sits at bits [2i+1:2i]. 01 is DATA-0 and 10 is DATA-1. `data_done` is 1 in the cycle after an edge at which every pair is 01 or 10. A single 00 pair keeps it 0.
- R4: A pair reading 11 sets `illegal_err` for the cycle after that edge. In the same cycle `data_done` and `null_done` are both 0.
- R5: While asleep, the stage wakes (`stage_sleep` falls, `prev_req_data` rises) at the second edge after an edge where the outputs read all NULL and `next_req_data` was 1. The wake happens only when both hold.
- R6: While asleep with `next_req_data`=0, or with outputs not all NULL, the block stays asleep with `prev_req_data`=0.
- R7: While awake and requesting DATA, the first cycle with `data_done`=1 makes `prev_req_data` fall at the next edge, and `stage_sleep` stays 0.
- R8: While holding DATA, the stage goes to sleep at the second edge after `next_req_data` is seen 0. It keeps `prev_req_data`=0 while `next_req_data` stays 1.
- R9: `stage_sleep` and `prev_req_data` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_rails | input | 2*PAIRS | Dual-rail outputs of the stage logic |
| next_req_data | input | 1 | Downstream request: 1 asks for DATA, 0 asks for NULL |
| prev_req_data | output | 1 | Upstream request: 1 asks for DATA, 0 asks for NULL |
| stage_sleep | output | 1 | Forces the stage logic to NULL when 1 |
| data_done | output | 1 | Registered complete-DATA flag |
| null_done | output | 1 | Registered complete-NULL flag |
| illegal_err | output | 1 | Registered flag for a pair reading 11 |

## Verification
The hardest case to reach is a stage that is asleep while its outputs are not NULL and the downstream stage already asks for DATA. The block must refuse to wake, and the wake must then be timed exactly two edges after the outputs finally clear. The stimulus reaches this case by putting a DATA set on the rails straight after the stage falls asleep, holding the downstream request high, and only then returning the rails to NULL. Partial and illegal sets are injected while the stage is awake, so that neither can be taken for a complete DATA set.

// File: rtl/stc_pkg.sv
// Package: shared encodings for the dual-rail stage controller.
// Assumes pair bit 0 is the DATA-0 rail and pair bit 1 is the DATA-1 rail.
package stc_pkg;

    typedef enum logic [1:0] {
        RAIL_NULL = 2'b00,
        RAIL_D0   = 2'b01,
        RAIL_D1   = 2'b10,
        RAIL_BAD  = 2'b11
    } rail_code_t;

    typedef enum logic [1:0] {
        HS_SLEEP = 2'b00,
        HS_EVAL  = 2'b01,
        HS_HOLD  = 2'b10
    } hs_state_t;

endpackage

// File: rtl/dr_pair_class.sv
// Classifies one dual-rail pair as NULL, valid DATA or illegal.
// Purely combinational; assumes the stc_pkg rail encoding.
module dr_pair_class
    import stc_pkg::*;
(
    input  logic [1:0] pair_in,
    output logic       is_null,
    output logic       is_data,
    output logic       is_bad
);

    // Decode the two rails into exactly one class flag.
    always_comb begin
        is_null = 1'b0;
        is_data = 1'b0;
        is_bad  = 1'b0;
        case (rail_code_t'(pair_in))
            RAIL_NULL: is_null = 1'b1;
            RAIL_D0,
            RAIL_D1:   is_data = 1'b1;
            default:   is_bad  = 1'b1;
        endcase
    end

endmodule

// File: rtl/dr_complete_detect.sv
// Completion detector over PAIRS dual-rail pairs.
// Reduces the per-pair classes and registers the full-set flags.
// Assumes the rails are already settled at each clock edge.
module dr_complete_detect #(
    parameter int PAIRS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*PAIRS-1:0] rails,
    output logic               set_data,
    output logic               set_null,
    output logic               set_bad
);

    logic [PAIRS-1:0] p_null;
    logic [PAIRS-1:0] p_data;
    logic [PAIRS-1:0] p_bad;

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        dr_pair_class u_cls (
            .pair_in (rails[2*i +: 2]),
            .is_null (p_null[i]),
            .is_data (p_data[i]),
            .is_bad  (p_bad[i])
        );
    end

    // Register the reduced full-set flags once per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_data <= 1'b0;
            set_null <= 1'b0;
            set_bad  <= 1'b0;
        end else begin
            set_data <= &p_data;
            set_null <= &p_null;
            set_bad  <= |p_bad;
        end
    end

endmodule

// File: rtl/stc_handshake_fsm.sv
// Handshake and sleep sequencer for one stage.
// Acts only on registered completion flags and on a registered copy
// of the downstream request, so its Moore outputs never glitch.
module stc_handshake_fsm
    import stc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_data,
    input  logic set_null,
    input  logic next_req,
    output logic req_data,
    output logic sleep
);

    hs_state_t state_q;
    hs_state_t state_d;
    logic      next_req_q;

    // Capture the downstream request.
    always_ff @(posedge clk) begin
        if (!rst_n) next_req_q <= 1'b0;
        else        next_req_q <= next_req;
    end

    // Next-state selection from completion flags and request.
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_SLEEP: if (set_null && next_req_q) state_d = HS_EVAL;
            HS_EVAL:  if (set_data)               state_d = HS_HOLD;
            HS_HOLD:  if (!next_req_q)            state_d = HS_SLEEP;
            default:                              state_d = HS_SLEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_SLEEP;
        else        state_q <= state_d;
    end

    // Moore decode of the outputs.
    always_comb begin
        sleep    = (state_q == HS_SLEEP);
        req_data = (state_q == HS_EVAL);
    end

endmodule

// File: rtl/mtncl_stage_ctrl.sv
// Top: stage controller for a sleepable dual-rail pipeline stage.
// Joins the completion detector and the handshake sequencer.
// Assumes the stage logic returns to NULL while stage_sleep is high.
module mtncl_stage_ctrl #(
    parameter int PAIRS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*PAIRS-1:0] stage_rails,
    input  logic               next_req_data,
    output logic               prev_req_data,
    output logic               stage_sleep,
    output logic               data_done,
    output logic               null_done,
    output logic               illegal_err
);

    logic cd_data;
    logic cd_null;
    logic cd_bad;

    dr_complete_detect #(.PAIRS(PAIRS)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rails    (stage_rails),
        .set_data (cd_data),
        .set_null (cd_null),
        .set_bad  (cd_bad)
    );

    stc_handshake_fsm u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_data (cd_data),
        .set_null (cd_null),
        .next_req (next_req_data),
        .req_data (prev_req_data),
        .sleep    (stage_sleep)
    );

    // Expose the completion flags.
    always_comb begin
        data_done   = cd_data;
        null_done   = cd_null;
        illegal_err = cd_bad;
    end

endmodule

// File: rtl/stc_checker.sv
// Checker for mtncl_stage_ctrl, attached with bind below.
module stc_checker (
    input logic clk,
    input logic rst_n,
    input logic next_req_data,
    input logic prev_req_data,
    input logic stage_sleep,
    input logic data_done,
    input logic null_done,
    input logic illegal_err
);

    a_r4_bad_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> (!data_done && !null_done));

    a_r5_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prev_req_data) |-> ($past(null_done) && $past(next_req_data, 2)));

    a_r7_rfn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prev_req_data) && !stage_sleep |-> $past(data_done));

    a_r8_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_sleep) |-> !$past(next_req_data, 2));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stage_sleep && prev_req_data));

endmodule

bind mtncl_stage_ctrl stc_checker u_stc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .next_req_data (next_req_data),
    .prev_req_data (prev_req_data),
    .stage_sleep   (stage_sleep),
    .data_done     (data_done),
    .null_done     (null_done),
    .illegal_err   (illegal_err)
);

// File: tb/mtncl_stage_ctrl_test.sv
module mtncl_stage_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rails = 8'h00;
    logic       nreq = 1'b0;
    logic       prev_req_data, stage_sleep, data_done, null_done, illegal_err;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    typedef struct {
        logic [4:0] v;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mtncl_stage_ctrl #(.PAIRS(4)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .stage_rails   (rails),
        .next_req_data (nreq),
        .prev_req_data (prev_req_data),
        .stage_sleep   (stage_sleep),
        .data_done     (data_done),
        .null_done     (null_done),
        .illegal_err   (illegal_err)
    );

    // Expected order: {sleep, req, data_done, null_done, illegal}.
    task automatic step(input logic [7:0] r, input logic n,
                        input logic [4:0] e, input string tag);
        @(negedge clk);
        rails = r;
        nreq  = n;
        sb.push_back('{e, tag});
    endtask

    // Monitor: pops one expectation after every edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e   = sb.pop_front();
                act = {stage_sleep, prev_req_data, data_done, null_done, illegal_err};
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s actual %b expected %b", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({stage_sleep, prev_req_data, data_done, null_done, illegal_err} !== 5'b10000) begin
            errors++;
            $display("FAIL R1 actual %b expected %b",
                     {stage_sleep, prev_req_data, data_done, null_done, illegal_err}, 5'b10000);
        end
        rst_n = 1'b1;
        step(8'h00, 1'b0, 5'b10010, "R2 null set");
        step(8'h00, 1'b0, 5'b10010, "R6 no request");
        step(8'h00, 1'b1, 5'b10010, "R5 request seen");
        step(8'h00, 1'b1, 5'b01010, "R5 wake");
        step(8'h54, 1'b1, 5'b01000, "R3 partial");
        step(8'h57, 1'b1, 5'b01001, "R4 illegal");
        step(8'h55, 1'b1, 5'b01100, "R3 all data0");
        step(8'h55, 1'b1, 5'b00100, "R7 rfn");
        step(8'h55, 1'b1, 5'b00100, "R8 hold");
        step(8'h55, 1'b0, 5'b00100, "R8 hold edge1");
        step(8'h55, 1'b0, 5'b10100, "R8 sleep");
        step(8'h00, 1'b0, 5'b10010, "R2 null again");
        step(8'h00, 1'b1, 5'b10010, "R6 waiting");
        step(8'h00, 1'b1, 5'b01010, "R5 wake again");
        step(8'h66, 1'b1, 5'b01100, "R3 mixed data");
        step(8'h66, 1'b1, 5'b00100, "R7 rfn mixed");
        step(8'h66, 1'b0, 5'b00100, "R8 hold mixed");
        step(8'h00, 1'b0, 5'b10010, "R8 sleep mixed");
        step(8'h55, 1'b1, 5'b10100, "R6 data asleep");
        step(8'h55, 1'b1, 5'b10100, "R6 no wake");
        step(8'h00, 1'b1, 5'b10010, "R6 cleared");
        step(8'h00, 1'b1, 5'b01010, "R5 late wake");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule